// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block runs one bus machine cycle at a time for a small 8-bit processor whose external bus shares the low address byte with the data byte, while the high address byte has its own pins. The caller offers a cycle through a valid/ready request port. The request carries the cycle kind (opcode fetch, memory read or memory write), the address and the write byte. The block then steps through the T-states, one per clock. It drives the latch strobe, the active-low read and write strobes and the three status bits. It also drives the shared bus or releases it, and it captures the read byte.

Back-pressure is simple. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high while the sequencer is idle and during the last T-state of a running cycle, and low otherwise. The caller must hold its request stable until it is taken. A one-clock `done` marks the last T-state. While `done` is high, `rd_data` holds the byte read by a fetch or read cycle. Taking a new request while `done` is high starts the next cycle with no idle clock in between.

Top module: `mcs_bus_sequencer`

## Requirements
- R1: While reset is held and right after it, the block is idle: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0, `req_ready`=1.
- R2: Request kinds are encoded as 0 = opcode fetch, 1 = memory read, 2 = memory write. Kind 3 is never taken, and it starts no cycle: `ale` and `done` stay low.
- R3: An opcode fetch lasts four T-states. A memory read or write lasts three T-states. `done` is high in the last T-state only.
- R4: `ale` is high only in the first T-state. In that T-state the low address byte is driven on `ad_out` with `ad_oe`=1. `a_hi` carries the high address byte in every T-state of the cycle.
- R5: `rd_n` is low only in the third T-state of a fetch or read. The byte on `ad_in` in that T-state is returned on `rd_data` while `done` is high.
- R6: `wr_n` is low only in the second T-state of a write. It stays high through fetch and read cycles.
- R7: In a write, the write byte is driven on `ad_out` with `ad_oe`=1 in the second and third T-states. In a fetch or read, the bus is released (`ad_oe`=0) after the first T-state.
- R8: The status bits {`io_m`,`s1`,`s0`} read 011 for a fetch, 010 for a read and 001 for a write through the whole cycle. They read 000 while idle.
- R9: A request taken in the last T-state of a cycle makes the next clock the first T-state of the new cycle.
- R10: The fourth T-state of a fetch keeps both strobes high and the bus released.
- R11: `req_ready` is low in every T-state of a running cycle except its last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_kind | input | 2 | Cycle kind: 0 fetch, 1 read, 2 write |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| ale | output | 1 | Address latch strobe, first T-state |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | IO/memory select, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ad_out | output | 8 | Value driven on the shared address/data bus |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Value seen on the shared bus |
| a_hi | output | 8 | High address byte |
| rd_data | output | 8 | Captured read byte, valid with done |
| done | output | 1 | Last T-state of the cycle |

## Verification
Two functions can land in the same clock: the closing T-state of one cycle, with `done` and the read data, and the acceptance of the next request. The bench provokes this by raising a new request while `done` is high. It then checks three things: the returned byte belongs to the finishing cycle, the very next clock shows `ale` with the new address, and the new status code appears at once. A second overlap is a read strobe and a write drive. Assertions forbid `ad_oe` while `rd_n` is low, and every vector checks the bus enable T-state by T-state.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_NONE  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } status_t;

  function automatic status_t status_of(kind_e k);
    status_t s;
    case (k)
      KIND_FETCH: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      KIND_READ:  s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      KIND_WRITE: s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      default:    s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mcs_timing.sv
module mcs_timing
  import mcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  kind_e   req_kind,
  output logic    req_ready,
  output logic    accept,
  output tstate_e ts,
  output kind_e   kind_q,
  output logic    last
);

  tstate_e ts_nxt;

  always_comb begin
    last = (ts == TS_T4) || ((ts == TS_T3) && (kind_q != KIND_FETCH));
  end

  assign req_ready = (ts == TS_IDLE) || last;
  assign accept    = req_valid && req_ready && (req_kind != KIND_NONE);

  always_comb begin
    ts_nxt = ts;
    if (accept) begin
      ts_nxt = TS_T1;
    end else if (last) begin
      ts_nxt = TS_IDLE;
    end else begin
      case (ts)
        TS_T1:   ts_nxt = TS_T2;
        TS_T2:   ts_nxt = TS_T3;
        TS_T3:   ts_nxt = TS_T4;
        default: ts_nxt = ts;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts     <= TS_IDLE;
      kind_q <= KIND_NONE;
    end else begin
      ts <= ts_nxt;
      if (accept) kind_q <= req_kind;
    end
  end

  // R3
  t4_only_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == TS_T4) |-> ($past(ts) == TS_T3 && kind_q == KIND_FETCH));

  // R3
  last_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last);

  // R9
  accept_to_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ts == TS_T1));

  // R2
  reserved_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == TS_T1) |-> (kind_q != KIND_NONE));

endmodule

// File: rtl/mcs_strobes.sv
module mcs_strobes
  import mcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tstate_e ts,
  input  kind_e   kind_q,
  output logic    ale,
  output logic    rd_n,
  output logic    wr_n,
  output logic    rd_phase,
  output status_t status
);

  logic active;

  assign active   = (ts != TS_IDLE);
  assign ale      = (ts == TS_T1);
  assign rd_phase = (ts == TS_T3) &&
                    ((kind_q == KIND_FETCH) || (kind_q == KIND_READ));
  assign rd_n     = !rd_phase;
  assign wr_n     = !((ts == TS_T2) && (kind_q == KIND_WRITE));

  always_comb begin
    status = active ? status_of(kind_q) : '0;
  end

  // R5
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ale && wr_n));

  // R6
  wr_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (kind_q == KIND_WRITE && rd_n));

  // R4
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R10
  t4_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == TS_T4) |-> (rd_n && wr_n && !ale));

endmodule

// File: rtl/mcs_datapath.sv
module mcs_datapath
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  tstate_e              ts,
  input  kind_e                kind_q,
  input  logic                 rd_phase,
  input  logic [DATA_W-1:0]    ad_in,
  output logic [DATA_W-1:0]    ad_out,
  output logic                 ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]    rd_data
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] cap_q;
  logic              addr_phase;
  logic              wr_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_q <= '0;
    else if (rd_phase) cap_q <= ad_in;
  end

  assign addr_phase = (ts == TS_T1);
  assign wr_drive   = (kind_q == KIND_WRITE) && ((ts == TS_T2) || (ts == TS_T3));
  assign ad_oe      = addr_phase || wr_drive;
  assign ad_out     = addr_phase ? addr_q[DATA_W-1:0] :
                      (wr_drive ? wdata_q : '0);
  assign a_hi       = (ts != TS_IDLE) ? addr_q[ADDR_W-1 -: HI_W] : '0;
  assign rd_data    = rd_phase ? ad_in : cap_q;

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> !ad_oe);

  // R4
  ale_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == TS_T1) |-> (ad_oe && ad_out == addr_q[DATA_W-1:0]));

  // R4
  hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ts == TS_T2) || (ts == TS_T3) || (ts == TS_T4)) |-> $stable(a_hi));

endmodule

// File: rtl/mcs_bus_sequencer.sv
module mcs_bus_sequencer
  import mcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     done
);

  kind_e   kind_in;
  kind_e   kind_q;
  tstate_e ts;
  logic    accept;
  logic    last;
  logic    rd_phase;
  status_t status;

  assign kind_in = kind_e'(req_kind);

  mcs_timing u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (kind_in),
    .req_ready (req_ready),
    .accept    (accept),
    .ts        (ts),
    .kind_q    (kind_q),
    .last      (last)
  );

  mcs_strobes u_strobes (
    .clk      (clk),
    .rst_n    (rst_n),
    .ts       (ts),
    .kind_q   (kind_q),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .rd_phase (rd_phase),
    .status   (status)
  );

  mcs_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ts        (ts),
    .kind_q    (kind_q),
    .rd_phase  (rd_phase),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .a_hi      (a_hi),
    .rd_data   (rd_data)
  );

  assign io_m = status.io_m;
  assign s1   = status.s1;
  assign s0   = status.s0;
  assign done = last;

  // R11
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == TS_T1 || ts == TS_T2) |-> !req_ready);

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts == TS_T2 || ts == TS_T3 || ts == TS_T4) |-> $stable({io_m, s1, s0}));

endmodule

// File: tb/tb_mcs_bus_sequencer.sv
module tb_mcs_bus_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       ale, rd_n, wr_n, io_m, s1, s0, ad_oe, done;
  logic [7:0] ad_out, a_hi, rd_data;
  logic [7:0] ad_in = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mcs_bus_sequencer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi),
    .rd_data(rd_data), .done(done)
  );

  // {kind[1:0], addr[15:0], wdata[7:0], bus_in[7:0]}
  localparam int NV = 6;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 16'h2000, 8'hEE, 8'h3E},
    {2'd1, 16'h2001, 8'h11, 8'h46},
    {2'd2, 16'h5000, 8'h27, 8'hC3},
    {2'd0, 16'hFFFF, 8'h00, 8'hA5},
    {2'd1, 16'h0000, 8'hFF, 8'h00},
    {2'd2, 16'h80FF, 8'h5A, 8'h99}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_req(input logic [33:0] v);
    req_kind  = v[33:32];
    req_addr  = v[31:16];
    req_wdata = v[15:8];
    req_valid = 1'b1;
  endtask

  // Walks one cycle whose request is already driven; block is idle or in its last T-state.
  task automatic walk(input logic [33:0] v, input bit chained,
                      input bit nxt_en, input logic [33:0] nxt);
    logic [1:0]  k    = v[33:32];
    logic [15:0] a    = v[31:16];
    logic [7:0]  wd   = v[15:8];
    logic [7:0]  bin  = v[7:0];
    int          n    = (k == 2'd0) ? 4 : 3;
    logic [2:0]  st   = (k == 2'd0) ? 3'b011 : ((k == 2'd1) ? 3'b010 : 3'b001);
    @(posedge clk);
    for (int t = 1; t <= n; t++) begin
      if (t > 1) @(posedge clk);
      @(negedge clk);
      if (t == 1) begin
        req_valid = 1'b0;
        ad_in = bin;
        if (chained) chk("R9 ale right after chained accept", {31'd0, ale}, 32'd1);
      end
      chk("R4 ale", {31'd0, ale}, {31'd0, t == 1});
      chk("R4 a_hi", {24'd0, a_hi}, {24'd0, a[15:8]});
      chk("R5 rd_n", {31'd0, rd_n}, {31'd0, !((k != 2'd2) && t == 3)});
      chk("R6 wr_n", {31'd0, wr_n}, {31'd0, !((k == 2'd2) && t == 2)});
      chk("R7 ad_oe", {31'd0, ad_oe},
          {31'd0, (t == 1) || ((k == 2'd2) && (t == 2 || t == 3))});
      if (t == 1) chk("R4 low address", {24'd0, ad_out}, {24'd0, a[7:0]});
      else if (k == 2'd2) chk("R7 write data", {24'd0, ad_out}, {24'd0, wd});
      chk("R8 status", {29'd0, io_m, s1, s0}, {29'd0, st});
      chk("R3 done", {31'd0, done}, {31'd0, t == n});
      chk("R11 ready", {31'd0, req_ready}, {31'd0, t == n});
      if (t == 4) chk("R10 quiet slot", {29'd0, rd_n, wr_n, ad_oe}, 32'b110);
      if (t == n && k != 2'd2) chk("R5 rd_data", {24'd0, rd_data}, {24'd0, bin});
      if (t == n && nxt_en) drive_req(nxt);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    chk("R1 ale in reset", {31'd0, ale}, 32'd0);
    chk("R1 strobes in reset", {30'd0, rd_n, wr_n}, 32'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle oe/done", {30'd0, ad_oe, done}, 32'd0);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R8 idle status", {29'd0, io_m, s1, s0}, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive_req(VEC[i]);
      walk(VEC[i], 1'b0, 1'b0, '0);
      @(negedge clk);
      chk("R3 back to idle", {31'd0, done}, 32'd0);
    end

    // R2: reserved kind refused
    req_kind = 2'd3; req_addr = 16'h1234; req_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R2 kind 3 no ale", {31'd0, ale}, 32'd0);
      chk("R2 kind 3 no done", {31'd0, done}, 32'd0);
      chk("R2 kind 3 status", {29'd0, io_m, s1, s0}, 32'd0);
    end
    req_valid = 1'b0;

    // R9: back-to-back chain fetch -> write -> read
    drive_req(VEC[0]);
    walk(VEC[0], 1'b0, 1'b1, VEC[2]);
    walk(VEC[2], 1'b1, 1'b1, VEC[1]);
    walk(VEC[1], 1'b1, 1'b0, '0);
    @(negedge clk);
    chk("R9 idle after chain", {30'd0, ale, done}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule